// File: doc/BRIEF.md
# Pipelined Binary-Polynomial Modular Multiplier

This block multiplies two binary polynomials (coefficients in GF(2)) and reduces the product modulo a polynomial supplied with each operation. It is one residue channel of a polynomial residue-class cipher datapath. A wider engine places several copies side by side, one for each modulus. Operands of degree below `DEG` enter on a valid strobe. The reduced product leaves on a matching strobe exactly `DEG` cycles later.

The multiplier operand is scanned from its lowest-order coefficient upward, with one pipeline stage for each coefficient. Every stage conditionally folds the running multiple of A into an accumulator. It then multiplies that running multiple by x and reduces it at once. Each stage is registered and there is no stall path, so a new operand set may be issued on every clock. The modulus travels down the pipe with its operands, so consecutive operations may use different moduli.

Top module: `gfm_mul_pipe`

## Requirements
- R1: When `in_valid` is high, `out_c` later equals A·B mod P over GF(2). Here A is `in_a` (degree below DEG), B is `in_b`, and P is x^DEG plus the polynomial held in `in_poly`. Bit i of each bus is the coefficient of x^i.
- R2: The running multiple of A is multiplied by x at every stage. If its x^(DEG-1) coefficient is 0, this is a plain one-place left shift. If that coefficient is 1, the shift is followed by an XOR with `in_poly`. For example, B = x with A's top bit set gives (A<<1) XOR P.
- R3: A zero coefficient of B leaves the accumulator of its stage unchanged. B = 0 or A = 0 therefore gives C = 0.
- R4: B = 1 returns C = A unchanged.
- R5: `out_valid` is high in exactly the cycle that lies DEG cycles after the cycle in which `in_valid` was high, with one result for every issued operand set. Issues on every clock are accepted with no gap.
- R6: Each operation is reduced by the modulus given with it, even when every consecutive issue carries a different `in_poly`.
- R7: A synchronous active-high `rst` clears every in-flight valid bit. `out_valid` is low in the cycle after a clock edge that sees `rst`, and stays low until operands issued after reset reach the output.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low DEG cycles later, so bubbles are preserved in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present this cycle |
| in_a | input | DEG | Multiplicand A, already reduced |
| in_b | input | DEG | Multiplier B, bit i is the x^i coefficient |
| in_poly | input | DEG | Modulus P without its implied x^DEG term |
| out_valid | output | 1 | Result present this cycle |
| out_c | output | DEG | Reduced product A·B mod P |

## Verification
The stage-local rules are checked by assertions on every cycle in every stage. These are the one-cycle valid hand-off, the clearing of valids by reset, the unchanged accumulator under a zero B coefficient, the plain shift of the multiplicand when no reduction is due, and the modulus and B travelling unchanged. Only the bench's end-to-end comparison can show the behaviours that span the whole pipe. These are that the full product is correct against an independent multiply-then-divide model, that latency is exactly DEG, that back-to-back issues with a fresh modulus each clock do not interfere, and that a reset in the middle of a stream drops every in-flight result.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

  // Default polynomial degree for one residue channel.
  localparam int GFM_DEG_DEFAULT = 8;

  // Cycles from issue to result: one registered stage per multiplier coefficient.
  function automatic int gfm_latency(input int deg);
    return deg;
  endfunction

endpackage

// File: rtl/gfm_xtime.sv
// Multiply a reduced polynomial by x, reducing modulo x^DEG + poly.
module gfm_xtime #(
  parameter int DEG = 8
) (
  input  logic [DEG-1:0] a_i,
  input  logic [DEG-1:0] poly_i,
  output logic [DEG-1:0] y_o
);

  logic             top_bit;
  logic [DEG-1:0]   shifted;

  always_comb begin
    top_bit = a_i[DEG-1];
    shifted = {a_i[DEG-2:0], 1'b0};
    y_o     = top_bit ? (shifted ^ poly_i) : shifted;
  end

endmodule

// File: rtl/gfm_stage.sv
// One pipeline stage: folds coefficient IDX of B, advances the multiple of A.
module gfm_stage #(
  parameter int DEG = 8,
  parameter int IDX = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vld_i,
  input  logic [DEG-1:0] acc_i,
  input  logic [DEG-1:0] mc_i,
  input  logic [DEG-1:0] b_i,
  input  logic [DEG-1:0] p_i,
  output logic           vld_o,
  output logic [DEG-1:0] acc_o,
  output logic [DEG-1:0] mc_o,
  output logic [DEG-1:0] b_o,
  output logic [DEG-1:0] p_o
);

  logic [DEG-1:0] acc_nxt;
  logic [DEG-1:0] mc_nxt;

  gfm_xtime #(.DEG(DEG)) u_xtime (
    .a_i    (mc_i),
    .poly_i (p_i),
    .y_o    (mc_nxt)
  );

  always_comb begin
    acc_nxt = b_i[IDX] ? (acc_i ^ mc_i) : acc_i;
  end

  // Only the valid bit is reset; data registers run free.
  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    acc_o <= acc_nxt;
    mc_o  <= mc_nxt;
    b_o   <= b_i;
    p_o   <= p_i;
  end

  // R5: valid advances exactly one stage per clock
  assert_valid_step_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld_o == $past(vld_i)));

  // R7: reset empties this stage on the following cycle
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> !vld_o);

  // R3: zero coefficient leaves the accumulator untouched
  assert_acc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(vld_i) && !$past(b_i[IDX])) |-> (acc_o == $past(acc_i)));

  // R2: without a carry out of the top coefficient, the multiple is a plain shift
  assert_shift_plain_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(vld_i) && !$past(mc_i[DEG-1])) |-> (mc_o == {$past(mc_i[DEG-2:0]), 1'b0}));

  // R6: modulus and multiplier travel unchanged with their operation
  assert_poly_carry_R6: assert property (@(posedge clk) disable iff (rst)
    $past(vld_i) |-> ((p_o == $past(p_i)) && (b_o == $past(b_i))));

endmodule

// File: rtl/gfm_mul_pipe.sv
// Fully pipelined GF(2) polynomial multiplier, LSB-first, reduced per stage.
module gfm_mul_pipe
  import gfm_pkg::*;
#(
  parameter int DEG = GFM_DEG_DEFAULT
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [DEG-1:0] in_a,
  input  logic [DEG-1:0] in_b,
  input  logic [DEG-1:0] in_poly,
  output logic           out_valid,
  output logic [DEG-1:0] out_c
);

  localparam int STAGES = gfm_latency(DEG);

  logic           vld_w [0:STAGES];
  logic [DEG-1:0] acc_w [0:STAGES];
  logic [DEG-1:0] mc_w  [0:STAGES];
  logic [DEG-1:0] b_w   [0:STAGES];
  logic [DEG-1:0] p_w   [0:STAGES];

  always_comb begin
    vld_w[0] = in_valid;
    acc_w[0] = '0;
    mc_w[0]  = in_a;
    b_w[0]   = in_b;
    p_w[0]   = in_poly;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    gfm_stage #(.DEG(DEG), .IDX(s)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .vld_i (vld_w[s]),
      .acc_i (acc_w[s]),
      .mc_i  (mc_w[s]),
      .b_i   (b_w[s]),
      .p_i   (p_w[s]),
      .vld_o (vld_w[s+1]),
      .acc_o (acc_w[s+1]),
      .mc_o  (mc_w[s+1]),
      .b_o   (b_w[s+1]),
      .p_o   (p_w[s+1])
    );
  end

  // Outputs come straight from the last stage's registers.
  assign out_valid = vld_w[STAGES];
  assign out_c     = acc_w[STAGES];

  // R3: an operation whose whole multiplier was zero leaves a zero product
  assert_zero_mult_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (b_w[STAGES] == '0)) |-> (out_c == '0));

endmodule

// File: tb/gfm_mul_pipe_bench.sv
module gfm_mul_pipe_bench;

  localparam int DEG = 8;
  localparam int RING = 64;

  logic           clk = 1'b0;
  logic           rst;
  logic           in_valid;
  logic [DEG-1:0] in_a, in_b, in_poly;
  logic           out_valid;
  logic [DEG-1:0] out_c;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  bit             exp_v   [0:RING-1];
  logic [DEG-1:0] exp_c   [0:RING-1];
  string          exp_tag [0:RING-1];

  gfm_mul_pipe #(.DEG(DEG)) u_gfm_mul_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_poly   (in_poly),
    .out_valid (out_valid),
    .out_c     (out_c)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  // Independent model: full carry-less product, then long division by P.
  function automatic logic [DEG-1:0] ref_mul(input logic [DEG-1:0] a,
                                             input logic [DEG-1:0] b,
                                             input logic [DEG-1:0] p);
    logic [2*DEG-2:0] prod;
    logic [2*DEG-2:0] ax;
    logic [2*DEG-2:0] px;
    prod = '0;
    ax = (2*DEG-1)'(a);
    px = (2*DEG-1)'({1'b1, p});
    for (int i = 0; i < DEG; i++)
      if (b[i]) prod = prod ^ (ax << i);
    for (int k = 2*DEG-2; k >= DEG; k--)
      if (prod[k]) prod = prod ^ (px << (k - DEG));
    return prod[DEG-1:0];
  endfunction

  task automatic summary();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  task automatic issue(input logic [DEG-1:0] a, input logic [DEG-1:0] b,
                       input logic [DEG-1:0] p, input string tag);
    int idx;
    @(posedge clk); #2;
    in_valid = 1'b1; in_a = a; in_b = b; in_poly = p;
    idx = (cyc + DEG) % RING;
    exp_v[idx] = 1'b1;
    exp_c[idx] = ref_mul(a, b, p);
    exp_tag[idx] = tag;
  endtask

  task automatic bubble();
    @(posedge clk); #2;
    in_valid = 1'b0;
    in_a = 8'hA5; in_b = 8'hFF; in_poly = 8'h1B;
  endtask

  task automatic mid_reset(input int n);
    @(posedge clk); #2;
    rst = 1'b1; in_valid = 1'b0;
    for (int j = 0; j < RING; j++)
      if (j != cyc % RING) begin exp_v[j] = 1'b0; exp_tag[j] = "R7"; end
    repeat (n) begin @(posedge clk); #2; end
    rst = 1'b0;
  endtask

  // Checker at the falling edge, away from the driving edge.
  always @(negedge clk) begin
    if (!done && cyc > 0) begin
      int idx;
      idx = cyc % RING;
      checks++;
      if (out_valid !== exp_v[idx]) begin
        bad++;
        $display("FAIL %s/R5 valid cyc=%0d actual=%b expected=%b",
                 exp_tag[idx], cyc, out_valid, exp_v[idx]);
      end else if (exp_v[idx]) begin
        checks++;
        if (out_c !== exp_c[idx]) begin
          bad++;
          $display("FAIL %s/R1 data cyc=%0d actual=%h expected=%h",
                   exp_tag[idx], cyc, out_c, exp_c[idx]);
        end
      end
      exp_v[idx] = 1'b0;
      exp_tag[idx] = "R8";
    end
  end

  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      summary();
    end
  end

  initial begin
    logic [DEG-1:0] ra, rb, rp;
    void'($urandom(32'd2024));
    for (int j = 0; j < RING; j++) begin exp_v[j] = 1'b0; exp_tag[j] = "R7"; end
    rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0; in_poly = '0;
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;

    // Directed corners
    issue(8'h00, 8'hC3, 8'h1B, "R3");   // A = 0
    issue(8'h9E, 8'h00, 8'h1B, "R3");   // B = 0
    issue(8'h9E, 8'h01, 8'h1B, "R4");   // B = 1 returns A
    issue(8'hFF, 8'h01, 8'h63, "R4");
    issue(8'h80, 8'h02, 8'h1B, "R2");   // x * x^7 -> reduction by P
    issue(8'h41, 8'h02, 8'h1D, "R2");   // plain shift
    issue(8'hFF, 8'hFF, 8'h1B, "R1");
    issue(8'h53, 8'hCA, 8'h1B, "R1");
    issue(8'h80, 8'h80, 8'h01, "R1");
    bubble();
    issue(8'h57, 8'h83, 8'h1B, "R8");
    bubble(); bubble();
    issue(8'h02, 8'h87, 8'h71, "R8");

    // Back-to-back with a fresh modulus every clock
    for (int i = 0; i < 200; i++) begin
      ra = 8'($urandom); rb = 8'($urandom); rp = 8'($urandom);
      issue(ra, rb, rp, "R6");
    end

    // Random stream with occasional bubbles
    for (int i = 0; i < 150; i++) begin
      if (($urandom % 5) == 0) bubble();
      else begin
        ra = 8'($urandom); rb = 8'($urandom); rp = 8'($urandom);
        issue(ra, rb, rp, "R5");
      end
    end

    // Reset while the pipe is full: all in-flight results must vanish
    mid_reset(3);
    repeat (DEG + 2) bubble();

    for (int i = 0; i < 40; i++) begin
      ra = 8'($urandom); rb = 8'($urandom); rp = 8'($urandom);
      issue(ra, rb, rp, "R1");
    end
    repeat (DEG + 4) bubble();
    @(posedge clk); #5;
    summary();
  end

endmodule